// File: doc/BRIEF.md
# Two-Port Block Transfer Sequencer

This block moves a block of bytes between two ports, A and B, on behalf of a register decoder. The decoder supplies each port's addressing mode, its memory or I/O type and its cycle timing. It also gives the transfer direction, the start addresses, the length, the ready polarity and three command strobes: load, enable and disable. The sequencer then owns the bus. Each byte is read from the source port into a holding latch and written from that latch to the destination port. Every access lasts the number of clocks set by that port's timing field.

A four-state machine controls the work. IDLE waits until the enable flag and the normalized ready are both 1 (IDLE→READ). READ drives the source address and read strobe for the source port's cycle length, captures the data on its last clock and moves to WRITE (READ→WRITE). WRITE drives the destination address, the write strobe and the latched byte for the destination port's cycle length. At the end of a write, WRITE goes to one of three states:
- FINISH, when the byte counter was 0 (WRITE→FINISH).
- READ, when the transfer may still run (WRITE→READ).
- IDLE, when ready or enable has dropped (WRITE→IDLE).

FINISH lasts one clock, raises the done pulse and returns to IDLE (FINISH→IDLE).

Top module: `dmaseq_top`

## Requirements
- R1: Each byte is a read cycle on the source port followed by a write cycle of the captured byte on the destination port. Port A is the source when `a_is_src`=1; otherwise port B is the source.
- R2: A port's access cycle lasts 4 − timing clocks, where timing is its 2-bit timing field (0→4, 1→3, 2→2, 3→1). The bus address is held steady for the whole cycle.
- R3: After each access, a port's address moves according to its 2-bit mode field: 00 decrements by one, 01 increments by one, and 10 or 11 hold the address. Addresses wrap modulo 2^16.
- R4: A port whose I/O flag is 0 uses `mem_rd`/`mem_wr`. A port whose I/O flag is 1 uses `io_rd`/`io_wr`. At most one strobe is active in any clock.
- R5: The byte counter decrements after every write. The block ends on the write made while the counter is 0, so a programmed length N moves N+1 bytes and leaves the counter at 0xFFFF.
- R6: At block end the enable flag clears and `done` is high for exactly one clock.
- R7: A transfer starts or continues only while the enable flag and the normalized ready are both 1, and `bus_hold` is 1 while a byte is in flight. If ready drops, the current read/write pair completes before the sequencer pauses. Raising ready again resumes the block where it stopped.
- R8: The ready pin passes through two flip-flops. The normalized ready equals the synchronized pin when `rdy_act_high`=1 and its inverse otherwise. It appears at `status[1]` two clock edges after the pin changes; all other status bits read 0.
- R9: `load_stb` copies both programmed addresses and the length into the working registers when no byte is in flight. While `bus_hold` is 1 it is ignored.
- R10: Reset leaves the machine in IDLE with the enable flag, the working addresses, the counter, the synchronizer flops and all strobes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_mode | input | 2 | Port A address mode (00 dec, 01 inc, 1x fixed) |
| b_mode | input | 2 | Port B address mode |
| a_io | input | 1 | Port A is I/O (1) or memory (0) |
| b_io | input | 1 | Port B is I/O (1) or memory (0) |
| a_timing | input | 2 | Port A timing field, cycle = 4 − value |
| b_timing | input | 2 | Port B timing field |
| a_is_src | input | 1 | 1: A→B, 0: B→A |
| rdy_act_high | input | 1 | Ready polarity select |
| prog_addr_a | input | 16 | Programmed start address, port A |
| prog_addr_b | input | 16 | Programmed start address, port B |
| prog_len | input | 16 | Programmed length N (N+1 bytes) |
| load_stb | input | 1 | Load working registers |
| en_set | input | 1 | Set enable flag |
| en_clr | input | 1 | Clear enable flag |
| rdy_pin | input | 1 | Asynchronous ready request |
| rd_data | input | 8 | Read data from the addressed port |
| bus_hold | output | 1 | Bus held from the CPU |
| bus_addr | output | 16 | Address of the current access |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| wr_data | output | 8 | Latched byte being written |
| done | output | 1 | One-clock end-of-block pulse |
| en_flag | output | 1 | Enable flag |
| status | output | 8 | Status byte, bit 1 = normalized ready |
| cur_addr_a | output | 16 | Working address, port A |
| cur_addr_b | output | 16 | Working address, port B |
| cur_count | output | 16 | Working byte counter |

## Verification
The hardest case to reach from the ports is ready falling in the middle of a byte. The pin passes through the synchronizer, so its effect lands a variable number of clocks later, and the pair in flight must still complete. The stimulus drops ready as soon as the first write strobe appears, during a slow four-clock cycle. It then checks that reads and writes are equal, that the counter matches the number of bytes moved and that the enable flag is still set. Finally it raises ready again and checks that the completed block equals an untouched run. A load strobe issued while the bus is held is checked the same way, through the final addresses.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } seq_state_t;

    localparam int TIMING_W = 2;
    localparam int CYC_W    = TIMING_W + 1;
    localparam int MODE_W   = 2;

    // clocks per access: 4 minus the timing field
    function automatic logic [CYC_W-1:0] cycle_clocks(input logic [TIMING_W-1:0] tim);
        return CYC_W'(4) - {1'b0, tim};
    endfunction

endpackage

// File: rtl/dmaseq_rdy_norm.sv
module dmaseq_rdy_norm #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic act_high,
    output logic norm
);
    logic [STAGES-1:0] sync_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign norm = sync_q[STAGES-1] ~^ act_high;
endmodule

// File: rtl/dmaseq_port_ptr.sv
module dmaseq_port_ptr #(
    parameter int AW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [AW-1:0]                 load_val,
    input  logic                          step,
    input  logic [dmaseq_pkg::MODE_W-1:0] mode,
    output logic [AW-1:0]                 addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            unique casez (mode)
                2'b1?:   addr <= addr;
                2'b01:   addr <= addr + AW'(1);
                default: addr <= addr - AW'(1);
            endcase
        end
    end
endmodule

// File: rtl/dmaseq_cyc_timer.sv
module dmaseq_cyc_timer
    import dmaseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CYC_W-1:0] len,
    output logic             last
);
    logic [CYC_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (start)          left_q <= len;
        else if (left_q != '0)   left_q <= left_q - CYC_W'(1);
    end

    assign last = (left_q == CYC_W'(1));
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
    import dmaseq_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int STAT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] a_mode,
    input  logic [MODE_W-1:0] b_mode,
    input  logic              a_io,
    input  logic              b_io,
    input  logic [TIMING_W-1:0] a_timing,
    input  logic [TIMING_W-1:0] b_timing,
    input  logic              a_is_src,
    input  logic              rdy_act_high,
    input  logic [AW-1:0]     prog_addr_a,
    input  logic [AW-1:0]     prog_addr_b,
    input  logic [CW-1:0]     prog_len,
    input  logic              load_stb,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              rdy_pin,
    input  logic [DW-1:0]     rd_data,
    output logic              bus_hold,
    output logic [AW-1:0]     bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DW-1:0]     wr_data,
    output logic              done,
    output logic              en_flag,
    output logic [STAT_W-1:0] status,
    output logic [AW-1:0]     cur_addr_a,
    output logic [AW-1:0]     cur_addr_b,
    output logic [CW-1:0]     cur_count
);
    localparam int RDY_BIT = 1;

    seq_state_t state_q, state_d;

    logic             rdy_norm;
    logic             run_ok;
    logic             cyc_last;
    logic             cyc_start;
    logic [CYC_W-1:0] cyc_len;
    logic [CYC_W-1:0] src_clocks, dst_clocks;
    logic             in_flight;
    logic             load_ok;
    logic             rd_end, wr_end, block_end;
    logic             step_a, step_b;
    logic             src_io, dst_io;
    logic [DW-1:0]    latch_q;
    logic [CW-1:0]    count_q;
    logic             en_q;

    // ready synchronizer and polarity
    dmaseq_rdy_norm #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (rdy_pin),
        .act_high (rdy_act_high),
        .norm     (rdy_norm)
    );

    assign run_ok    = en_q & rdy_norm;
    assign in_flight = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign load_ok   = load_stb & ~in_flight;

    assign src_clocks = a_is_src ? cycle_clocks(a_timing) : cycle_clocks(b_timing);
    assign dst_clocks = a_is_src ? cycle_clocks(b_timing) : cycle_clocks(a_timing);
    assign src_io     = a_is_src ? a_io : b_io;
    assign dst_io     = a_is_src ? b_io : a_io;

    assign rd_end    = (state_q == ST_READ)  && cyc_last;
    assign wr_end    = (state_q == ST_WRITE) && cyc_last;
    assign block_end = wr_end && (count_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run_ok) state_d = ST_READ;
            ST_READ:   if (cyc_last) state_d = ST_WRITE;
            ST_WRITE: begin
                if (cyc_last) begin
                    if (count_q == '0) state_d = ST_FINISH;
                    else if (run_ok)   state_d = ST_READ;
                    else               state_d = ST_IDLE;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign cyc_start = (state_d != state_q) &&
                       ((state_d == ST_READ) || (state_d == ST_WRITE));
    assign cyc_len   = (state_d == ST_READ) ? src_clocks : dst_clocks;

    dmaseq_cyc_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cyc_start),
        .len   (cyc_len),
        .last  (cyc_last)
    );

    // address pointers, one per port
    assign step_a = a_is_src ? rd_end : wr_end;
    assign step_b = a_is_src ? wr_end : rd_end;

    dmaseq_port_ptr #(.AW(AW)) u_ptr_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (prog_addr_a),
        .step     (step_a),
        .mode     (a_mode),
        .addr     (cur_addr_a)
    );

    dmaseq_port_ptr #(.AW(AW)) u_ptr_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (prog_addr_b),
        .step     (step_b),
        .mode     (b_mode),
        .addr     (cur_addr_b)
    );

    // byte counter, data latch and enable flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            latch_q <= '0;
            en_q    <= 1'b0;
        end else begin
            if (load_ok)     count_q <= prog_len;
            else if (wr_end) count_q <= count_q - CW'(1);

            if (rd_end) latch_q <= rd_data;

            if (block_end)   en_q <= 1'b0;
            else if (en_clr) en_q <= 1'b0;
            else if (en_set) en_q <= 1'b1;
        end
    end

    // outputs decoded from the state
    always_comb begin
        bus_hold = 1'b0;
        bus_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                bus_hold = 1'b1;
                bus_addr = a_is_src ? cur_addr_a : cur_addr_b;
                io_rd    = src_io;
                mem_rd   = ~src_io;
            end
            ST_WRITE: begin
                bus_hold = 1'b1;
                bus_addr = a_is_src ? cur_addr_b : cur_addr_a;
                io_wr    = dst_io;
                mem_wr   = ~dst_io;
            end
            ST_FINISH: done = 1'b1;
        endcase
    end

    assign wr_data   = latch_q;
    assign en_flag   = en_q;
    assign cur_count = count_q;

    always_comb begin
        status          = '0;
        status[RDY_BIT] = rdy_norm;
    end
endmodule

// File: rtl/dmaseq_checker.sv
module dmaseq_checker #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_hold,
    input logic [AW-1:0] bus_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          io_rd,
    input logic          io_wr,
    input logic          done,
    input logic          en_flag,
    input logic [CW-1:0] cur_count
);
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

    a_r7_hold_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> ($countones({mem_rd, mem_wr, io_rd, io_wr}) == 1));

    a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hold) |-> $past(en_flag));

    a_r1_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr | io_wr) |-> $past(mem_rd | io_rd));

    a_r2_read_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> $stable(bus_addr));

    a_r6_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !en_flag);

    a_r5_count_wrapped: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_count == '1));
endmodule

bind dmaseq_top dmaseq_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_hold  (bus_hold),
    .bus_addr  (bus_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .done      (done),
    .en_flag   (en_flag),
    .cur_count (cur_count)
);

// File: tb/dmaseq_top_test.sv
`timescale 1ns/1ps
module dmaseq_top_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [1:0]  a_mode, b_mode, a_timing, b_timing;
    logic        a_io, b_io, a_is_src, rdy_act_high;
    logic [15:0] prog_addr_a, prog_addr_b, prog_len;
    logic        load_stb, en_set, en_clr, rdy_pin;
    logic [7:0]  rd_data;
    logic        bus_hold, mem_rd, mem_wr, io_rd, io_wr, done, en_flag;
    logic [15:0] bus_addr, cur_addr_a, cur_addr_b, cur_count;
    logic [7:0]  wr_data, status;

    dmaseq_top uut (
        .clk(clk), .rst_n(rst_n), .a_mode(a_mode), .b_mode(b_mode),
        .a_io(a_io), .b_io(b_io), .a_timing(a_timing), .b_timing(b_timing),
        .a_is_src(a_is_src), .rdy_act_high(rdy_act_high),
        .prog_addr_a(prog_addr_a), .prog_addr_b(prog_addr_b), .prog_len(prog_len),
        .load_stb(load_stb), .en_set(en_set), .en_clr(en_clr), .rdy_pin(rdy_pin),
        .rd_data(rd_data), .bus_hold(bus_hold), .bus_addr(bus_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .wr_data(wr_data), .done(done), .en_flag(en_flag), .status(status),
        .cur_addr_a(cur_addr_a), .cur_addr_b(cur_addr_b), .cur_count(cur_count)
    );

    // bus models: 256-byte memory and I/O spaces
    logic [7:0] mem_m [256];
    logic [7:0] io_m  [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_io  [256];
    logic       mem_init;
    logic [7:0] seed;

    assign rd_data = mem_rd ? mem_m[bus_addr[7:0]] :
                     (io_rd ? io_m[bus_addr[7:0]] : 8'h00);

    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 256; i++) begin
                mem_m[i] <= 8'(i) ^ seed;
                io_m[i]  <= ~(8'(i) + seed);
            end
        end else begin
            if (mem_wr) mem_m[bus_addr[7:0]] <= wr_data;
            if (io_wr)  io_m[bus_addr[7:0]]  <= wr_data;
        end
    end

    // strobe monitor
    logic mon_clr;
    int   n_reads, n_writes, n_done, rd_run, wr_run, rd_width, wr_width;
    logic rd_prev, wr_prev;
    always @(posedge clk) begin
        if (mon_clr) begin
            n_reads <= 0; n_writes <= 0; n_done <= 0;
            rd_run <= 0; wr_run <= 0; rd_width <= 0; wr_width <= 0;
            rd_prev <= 1'b0; wr_prev <= 1'b0;
        end else begin
            rd_prev <= mem_rd | io_rd;
            wr_prev <= mem_wr | io_wr;
            if (done) n_done <= n_done + 1;
            if ((mem_rd | io_rd) && !rd_prev) n_reads <= n_reads + 1;
            if ((mem_wr | io_wr) && !wr_prev) n_writes <= n_writes + 1;
            if (mem_rd | io_rd) rd_run <= rd_prev ? rd_run + 1 : 1;
            else if (rd_prev)   rd_width <= rd_run;
            if (mem_wr | io_wr) wr_run <= wr_prev ? wr_run + 1 : 1;
            else if (wr_prev)   wr_width <= wr_run;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not end actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    typedef struct packed {
        logic [1:0]  am;
        logic [1:0]  bm;
        logic        aio;
        logic        bio;
        logic [1:0]  ta;
        logic [1:0]  tb;
        logic        asrc;
        logic        ahi;
        logic [15:0] aa;
        logic [15:0] ab;
        logic [15:0] len;
        logic        pz;
        logic        ldm;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 2'b01, 1'b0, 1'b0, 2'd0, 2'd3, 1'b1, 1'b1, 16'h0010, 16'h0080, 16'd3, 1'b0, 1'b0},
        '{2'b00, 2'b01, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 16'h0040, 16'h0020, 16'd5, 1'b0, 1'b0},
        '{2'b10, 2'b01, 1'b0, 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 16'h0033, 16'h0005, 16'd2, 1'b0, 1'b0},
        '{2'b00, 2'b00, 1'b0, 1'b0, 2'd3, 2'd3, 1'b1, 1'b1, 16'h0000, 16'h00F1, 16'd0, 1'b0, 1'b0},
        '{2'b01, 2'b11, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 16'h0090, 16'h0007, 16'd9, 1'b1, 1'b0},
        '{2'b01, 2'b00, 1'b0, 1'b0, 2'd3, 2'd2, 1'b0, 1'b0, 16'h0060, 16'h00C0, 16'd4, 1'b0, 1'b1}
    };

    function automatic logic [15:0] step_of(input logic [1:0] m);
        if (m[1])      return 16'h0000;
        else if (m[0]) return 16'h0001;
        else           return 16'hFFFF;
    endfunction

    task automatic build_expect(input vec_t t);
        logic [15:0] sa, da, ss, ds;
        logic        sio, dio;
        logic [7:0]  b;
        for (int i = 0; i < 256; i++) begin
            exp_mem[i] = mem_m[i];
            exp_io[i]  = io_m[i];
        end
        sa  = t.asrc ? t.aa : t.ab;
        da  = t.asrc ? t.ab : t.aa;
        ss  = t.asrc ? step_of(t.am) : step_of(t.bm);
        ds  = t.asrc ? step_of(t.bm) : step_of(t.am);
        sio = t.asrc ? t.aio : t.bio;
        dio = t.asrc ? t.bio : t.aio;
        for (int k = 0; k <= int'(t.len); k++) begin
            b = sio ? exp_io[sa[7:0]] : exp_mem[sa[7:0]];
            if (dio) exp_io[da[7:0]] = b;
            else     exp_mem[da[7:0]] = b;
            sa = sa + ss;
            da = da + ds;
        end
    endtask

    task automatic run_vec(input vec_t t, input int idx);
        int guard;
        int bad_bytes;
        @(negedge clk);
        a_mode = t.am; b_mode = t.bm; a_io = t.aio; b_io = t.bio;
        a_timing = t.ta; b_timing = t.tb; a_is_src = t.asrc;
        rdy_act_high = t.ahi; prog_addr_a = t.aa; prog_addr_b = t.ab;
        prog_len = t.len; seed = 8'(8'h31 + 8'(idx * 17));
        mem_init = 1'b1;
        @(negedge clk);
        mem_init = 1'b0;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        rdy_pin = t.ahi;
        repeat (3) @(negedge clk);
        // R9: load copies the programmed values
        chk("R9", "loaded addr A", cur_addr_a, t.aa);
        chk("R9", "loaded count", cur_count, t.len);
        build_expect(t);
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
        en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;

        if (t.ldm) begin
            guard = 0;
            while (!bus_hold && guard < 100) begin @(negedge clk); guard++; end
            prog_addr_a = 16'hBEEF; prog_addr_b = 16'h1234; prog_len = 16'h0777;
            load_stb = 1'b1;
            @(negedge clk);
            load_stb = 1'b0;
            prog_addr_a = t.aa; prog_addr_b = t.ab; prog_len = t.len;
        end

        if (t.pz) begin
            guard = 0;
            while (!(mem_wr | io_wr) && guard < 100) begin @(negedge clk); guard++; end
            rdy_pin = ~t.ahi;
            repeat (30) @(negedge clk);
            // R7: paused after a whole pair, enable still held
            chk("R7", "pause bus_hold", bus_hold, 0);
            chk("R7", "pause reads==writes", n_reads, n_writes);
            chk("R7", "pause enable kept", en_flag, 1);
            chk("R5", "pause count", cur_count, 16'(t.len - 16'(n_writes)));
            chk("R6", "no done while paused", n_done, 0);
            rdy_pin = t.ahi;
        end

        guard = 0;
        while (n_done == 0 && guard < 5000) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);

        chk("R6", "done pulse count", n_done, 1);
        chk("R6", "enable cleared", en_flag, 0);
        chk("R5", "final count", cur_count, 16'hFFFF);
        chk("R5", "bytes written", n_writes, int'(t.len) + 1);
        chk("R1", "bytes read", n_reads, int'(t.len) + 1);
        chk("R3", "final addr A", cur_addr_a,
            16'(t.aa + step_of(t.am) * (t.len + 16'd1)));
        chk("R3", "final addr B", cur_addr_b,
            16'(t.ab + step_of(t.bm) * (t.len + 16'd1)));
        chk("R2", "read cycle clocks", rd_width,
            4 - int'(t.asrc ? t.ta : t.tb));
        if (t.len != 0)
            chk("R2", "write cycle clocks", wr_width,
                4 - int'(t.asrc ? t.tb : t.ta));
        bad_bytes = 0;
        for (int i = 0; i < 256; i++) begin
            if (mem_m[i] !== exp_mem[i]) bad_bytes++;
            if (io_m[i]  !== exp_io[i])  bad_bytes++;
        end
        // R1 data path and R4 memory/I-O space selection
        chk("R4", "bytes in wrong space or value", bad_bytes, 0);
        chk("R7", "idle after block", bus_hold, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        a_mode = 2'b01; b_mode = 2'b01; a_io = 1'b0; b_io = 1'b0;
        a_timing = 2'd0; b_timing = 2'd0; a_is_src = 1'b1; rdy_act_high = 1'b1;
        prog_addr_a = 16'h0; prog_addr_b = 16'h0; prog_len = 16'h0;
        load_stb = 1'b0; en_set = 1'b0; en_clr = 1'b0; rdy_pin = 1'b0;
        mem_init = 1'b1; seed = 8'h00; mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "bus_hold", bus_hold, 0);
        chk("R10", "strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
        chk("R10", "enable", en_flag, 0);
        chk("R10", "count", cur_count, 0);
        chk("R10", "addr A", cur_addr_a, 0);
        chk("R10", "status", status, 0);
        rst_n = 1'b1;
        mem_init = 1'b0;
        mon_clr = 1'b0;
        @(negedge clk);

        // R8: two-edge synchronizer latency, active-high polarity
        rdy_pin = 1'b1;
        @(negedge clk);
        chk("R8", "status after one edge", status[1], 0);
        @(negedge clk);
        chk("R8", "status after two edges", status[1], 1);
        chk("R8", "other status bits", status & 8'hFD, 0);
        rdy_act_high = 1'b0;
        #1;
        chk("R8", "inverted polarity", status[1], 0);
        rdy_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "active-low ready", status[1], 1);

        // R7: ready alone does not start a transfer
        repeat (10) @(negedge clk);
        chk("R7", "no start without enable", bus_hold, 0);
        chk("R7", "no strobes without enable", n_reads, 0);

        for (int v = 0; v < NV; v++) run_vec(VECS[v], v);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule